// File: doc/BRIEF.md
# Shared Lock Arbiter with Holder Liveness Watchdog

This block is a hardware lock shared by several processors. Each processor has an acquire request line and a release strobe, and it sees one grant bit. Taking the lock is indivisible: if the lock is free on a clock edge, exactly one requesting processor becomes the holder on that edge. Requests that arrive at the same time are settled by a rotating priority.

While a processor holds the lock, it must keep its alive bit high. The block watches that bit only while some other processor is waiting for the lock. If the holder's alive bit stays low for a programmable number of such waiting cycles in a row, the block assumes the holder has died. It then takes the lock back, pulses an eviction flag that carries the dead holder's index, and hands the lock to one waiting processor on the next edge. Waiters therefore never spin forever behind a crashed holder. A short drop of the alive bit is filtered out because the count starts again.

Top module: `lockg_top`

## Requirements
- R1: While reset is asserted and after it is released, with no request present, every grant bit is 0 and `evict_pulse` is 0.
- R2: At most one grant bit is ever 1. When the lock is free and at least one `acq_req` bit is 1 on a rising edge, exactly one grant bit is 1 after that edge.
- R3: The winner among simultaneous requests is the first requesting index at or above a rotating pointer, wrapping from N_REQ-1 to 0. The pointer is 0 after reset and becomes the winner's index plus one (modulo N_REQ) on every grant.
- R4: While the lock is held, the grant stays with the holder, whatever the other requests do, as long as the holder does not release it and its alive bit is 1. The holder's own `acq_req` has no effect.
- R5: A `rel_stb` pulse from the holder clears its grant on the next rising edge. The lock is then free and can be granted on the edge after that.
- R6: A `rel_stb` from any processor other than the holder has no effect on the grant.
- R7: A waiting cycle is a cycle in which the holder's alive bit is 0, the holder is not releasing, and at least one other processor requests. The lock is force-released on the edge that ends the `stale_limit`-th waiting cycle in a row. A `stale_limit` of 0 acts as 1. Any cycle that is not a waiting cycle restarts the count.
- R8: A forced release drops the grant on that same edge. It raises `evict_pulse` for exactly one cycle, with `evict_id` equal to the index of the evicted holder.
- R9: On the edge after a forced release, exactly one of the processors still requesting is granted, chosen as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_req | input | N_REQ | Acquire request, one bit per processor |
| rel_stb | input | N_REQ | Release strobe, one bit per processor |
| alive | input | N_REQ | Alive heartbeat, one bit per processor |
| stale_limit | input | TMO_W | Number of consecutive waiting cycles before eviction (0 acts as 1) |
| grant | output | N_REQ | One-hot grant to the current holder, all zero when the lock is free |
| evict_pulse | output | 1 | One-cycle flag marking a forced release |
| evict_id | output | $clog2(N_REQ) | Index of the evicted holder, valid while evict_pulse is 1 |

## Verification
A grant appears one rising edge after a request finds the lock free. A holder release removes the grant one edge after the strobe. An eviction shows on the edge that ends the `stale_limit`-th waiting cycle, and the next holder's grant follows one edge later. The bench changes its inputs on falling edges and reads the outputs on the next falling edge. Its behavioural model advances on the rising edge in between, so every compare sees exactly the one register stage that the requirements describe. Directed sequences cover an interrupted eviction count, a limit of zero, and releases from a processor that does not hold the lock. A random phase then compares against the model on every cycle.

// File: rtl/lockg_pkg.sv
package lockg_pkg;
   typedef enum logic {
      LK_FREE = 1'b0,
      LK_HELD = 1'b1
   } lk_state_e;
endpackage

// File: rtl/lockg_rr_pick.sv
module lockg_rr_pick #(
   parameter int N_REQ = 4,
   localparam int IW = $clog2(N_REQ)
) (
   input  logic [N_REQ-1:0] req,
   input  logic [IW-1:0]    ptr,
   output logic             any,
   output logic [IW-1:0]    win
);
   always_comb begin
      any = 1'b0;
      win = '0;
      for (int k = N_REQ - 1; k >= 0; k--) begin
         int s;
         s = int'(ptr) + k;
         if (s >= N_REQ) s = s - N_REQ;
         if (req[s]) begin
            any = 1'b1;
            win = IW'(s);
         end
      end
   end
endmodule

// File: rtl/lockg_stale_timer.sv
module lockg_stale_timer #(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   logic [TMO_W-1:0] cnt;
   logic [TMO_W:0]   eff_lim;
   logic [TMO_W:0]   cnt_nxt;

   assign eff_lim = (limit == '0) ? (TMO_W+1)'(1) : {1'b0, limit};
   assign cnt_nxt = {1'b0, cnt} + (TMO_W+1)'(1);
   assign expire  = arm && (cnt_nxt >= eff_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!arm || expire) begin
         cnt <= '0;
      end else begin
         cnt <= cnt_nxt[TMO_W-1:0];
      end
   end

   // R7: a count that restarts cannot expire on the following cycle unless the limit is one
   assert_restart_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && limit > 1) |=> !expire || $changed(limit));
endmodule

// File: rtl/lockg_top.sv
module lockg_top
   import lockg_pkg::*;
#(
   parameter int N_REQ = 4,
   parameter int TMO_W = 8,
   localparam int IW = $clog2(N_REQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] acq_req,
   input  logic [N_REQ-1:0] rel_stb,
   input  logic [N_REQ-1:0] alive,
   input  logic [TMO_W-1:0] stale_limit,
   output logic [N_REQ-1:0] grant,
   output logic             evict_pulse,
   output logic [IW-1:0]    evict_id
);
   if (N_REQ < 2) begin : g_bad_nreq
      $error("lockg_top: N_REQ must be at least 2");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("lockg_top: TMO_W must be at least 1");
   end

   lk_state_e     st;
   logic [IW-1:0] owner;
   logic [IW-1:0] ptr;
   logic          evict_q;
   logic [IW-1:0] evict_id_q;

   logic          pick_any;
   logic [IW-1:0] pick_win;
   logic          waiter;
   logic          holder_rel;
   logic          holder_dead;
   logic          arm;
   logic          expire;

   for (genvar i = 0; i < N_REQ; i++) begin : g_grant
      assign grant[i] = (st == LK_HELD) && (owner == IW'(i));
   end

   assign waiter      = |(acq_req & ~grant);
   assign holder_rel  = rel_stb[owner];
   assign holder_dead = !alive[owner];
   assign arm         = (st == LK_HELD) && !holder_rel && holder_dead && waiter;

   lockg_rr_pick #(.N_REQ(N_REQ)) u_pick (
      .req (acq_req),
      .ptr (ptr),
      .any (pick_any),
      .win (pick_win)
   );

   lockg_stale_timer #(.TMO_W(TMO_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm),
      .limit  (stale_limit),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= LK_FREE;
         owner      <= '0;
         ptr        <= '0;
         evict_q    <= 1'b0;
         evict_id_q <= '0;
      end else begin
         evict_q <= 1'b0;
         if (st == LK_HELD) begin
            if (holder_rel) begin
               st <= LK_FREE;
            end else if (expire) begin
               st         <= LK_FREE;
               evict_q    <= 1'b1;
               evict_id_q <= owner;
            end
         end else if (pick_any) begin
            st    <= LK_HELD;
            owner <= pick_win;
            ptr   <= (pick_win == IW'(N_REQ - 1)) ? '0 : pick_win + IW'(1);
         end
      end
   end

   assign evict_pulse = evict_q;
   assign evict_id    = evict_id_q;

   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_free_req_grants_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0 && acq_req != '0) |=> $countones(grant) == 1);

   // R4 and R6: only a holder release or a dead holder can move the grant
   assert_keep_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && (grant & rel_stb) == '0 && (grant & alive) != '0) |=> grant == $past(grant));

   assert_holder_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & rel_stb) != '0) |=> grant == '0);

   assert_evict_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evict_pulse) |-> $past(grant != '0 && (grant & alive) == '0 && (acq_req & ~grant) != '0));

   assert_evict_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evict_pulse |-> grant == '0);

   assert_after_evict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_pulse && acq_req != '0) |=> $countones(grant) == 1 && !evict_pulse);
endmodule

// File: tb/sim_lockg_top.sv
module sim_lockg_top;
   localparam int N  = 4;
   localparam int TW = 8;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  acq_req = '0;
   logic [N-1:0]  rel_stb = '0;
   logic [N-1:0]  alive = '1;
   logic [TW-1:0] stale_limit = 8'd3;
   logic [N-1:0]  grant;
   logic          evict_pulse;
   logic [IW-1:0] evict_id;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   bit cmp_on = 0;

   // reference model state
   bit m_locked;
   int m_owner, m_cnt, m_ptr, m_evid;
   bit m_evict;

   always #4 clk = ~clk;

   lockg_top #(.N_REQ(N), .TMO_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_stb(rel_stb),
      .alive(alive), .stale_limit(stale_limit), .grant(grant),
      .evict_pulse(evict_pulse), .evict_id(evict_id)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_locked = 0; m_owner = 0; m_cnt = 0; m_ptr = 0; m_evict = 0; m_evid = 0;
      end else begin
         m_evict = 0;
         if (m_locked) begin
            bit wt;
            int lim;
            wt = 0;
            for (int i = 0; i < N; i++) if (i != m_owner && acq_req[i]) wt = 1;
            lim = (stale_limit == 0) ? 1 : int'(stale_limit);
            if (rel_stb[m_owner]) begin
               m_locked = 0; m_cnt = 0;
            end else if (!alive[m_owner] && wt) begin
               if (m_cnt + 1 >= lim) begin
                  m_locked = 0; m_cnt = 0; m_evict = 1; m_evid = m_owner;
               end else begin
                  m_cnt = m_cnt + 1;
               end
            end else begin
               m_cnt = 0;
            end
         end else begin
            int w;
            w = -1;
            for (int k = 0; k < N; k++)
               if (w < 0 && acq_req[(m_ptr + k) % N]) w = (m_ptr + k) % N;
            if (w >= 0) begin
               m_locked = 1; m_owner = w; m_ptr = (w + 1) % N; m_cnt = 0;
            end
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk("R2 R3 model grant", 32'(grant), m_locked ? 32'(1 << m_owner) : 32'd0);
         chk("R8 model evict_pulse", 32'(evict_pulse), 32'(m_evict));
         if (m_evict) chk("R8 model evict_id", 32'(evict_id), 32'(m_evid));
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset grant", 32'(grant), 32'd0);
      chk("R1 reset evict", 32'(evict_pulse), 32'd0);
      rst_n = 1'b1;
      tick();
      chk("R1 idle grant", 32'(grant), 32'd0);
      cmp_on = 1;

      acq_req = 4'b0110;
      tick();
      chk("R2 R3 first grant", 32'(grant), 32'b0010);

      acq_req = 4'b1111;
      tick(3);
      chk("R4 holder keeps lock", 32'(grant), 32'b0010);

      rel_stb = 4'b0100;
      tick();
      rel_stb = '0;
      chk("R6 non-holder release ignored", 32'(grant), 32'b0010);

      rel_stb = 4'b0010;
      acq_req = 4'b1101;
      tick();
      rel_stb = '0;
      chk("R5 holder release", 32'(grant), 32'd0);
      acq_req = 4'b1100;
      tick();
      chk("R3 rotate to index 2", 32'(grant), 32'b0100);

      stale_limit = 8'd3;
      alive = 4'b1011;
      acq_req = 4'b1001;
      tick(2);
      acq_req = 4'b0000;
      tick();
      chk("R7 no waiter restarts count", 32'(grant), 32'b0100);
      acq_req = 4'b1001;
      tick(2);
      chk("R7 before limit", 32'(grant), 32'b0100);
      chk("R7 no early evict", 32'(evict_pulse), 32'd0);
      tick();
      chk("R8 grant dropped", 32'(grant), 32'd0);
      chk("R8 evict pulse", 32'(evict_pulse), 32'd1);
      chk("R8 evict id", 32'(evict_id), 32'd2);
      tick();
      chk("R9 waiter granted", 32'(grant), 32'b1000);
      chk("R8 pulse one cycle", 32'(evict_pulse), 32'd0);

      stale_limit = 8'd0;
      alive = 4'b0111;
      acq_req = 4'b0001;
      tick();
      chk("R7 limit zero acts as one", 32'(evict_pulse), 32'd1);
      chk("R8 evict id 3", 32'(evict_id), 32'd3);
      tick();
      chk("R9 next waiter", 32'(grant), 32'b0001);

      alive = '1;
      acq_req = '0;
      rel_stb = 4'b0001;
      tick();
      rel_stb = '0;
      for (int c = 0; c < 600; c++) begin
         acq_req = 4'($urandom);
         rel_stb = (($urandom % 6) == 0) ? 4'($urandom) : 4'b0000;
         for (int i = 0; i < N; i++) alive[i] = (($urandom % 10) != 0);
         if (($urandom % 50) == 0) stale_limit = 8'($urandom % 5);
         tick();
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule